// File: doc/BRIEF.md
# Cascadable Eight-Line Priority Interrupt Controller

The block collects eight level-sensitive interrupt request lines, ranks them by fixed priority, and raises a single interrupt output toward a processor. The processor answers with an acknowledge pulse. The controller then returns an 8-bit vector that identifies the winning line and records that line as in service until software retires it. Software reaches the block through a byte-wide port with one address bit. The even address takes commands and returns a status register. The odd address carries the mask and the configuration bytes.

A role input selects master or slave, so two instances can be chained. A slave's interrupt output drives one request line of the master. When the master acknowledges that line, it sends the line number over a select bus instead of supplying a vector. The slave whose identity matches that number supplies the vector. A short configuration sequence sets three things: the vector base, which lines carry slaves (or, for a slave, its identity), and whether in-service bits are retired automatically. If the winning request disappears before the acknowledge arrives, the block still answers, using the lowest-priority line's vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service register is 0, even-address reads return the request register, and the interrupt output and vector-valid are low.
- R2: An even-address write with bit 4 set starts configuration. The next three odd-address writes are taken as vector base, cascade byte and mode byte. None of these three writes changes the mask.
- R3: A mode byte with bit 0 clear is rejected, and the sequence keeps waiting for a mode byte. A mode byte with bit 0 set ends configuration, and its bit 1 selects automatic retirement.
- R4: Outside configuration, an odd-address write loads the mask and an odd-address read returns it. A mask bit of 1 keeps its line from raising the interrupt output.
- R5: Line 0 has the highest priority and line 7 the lowest. The interrupt output is high while any unmasked request has higher priority than every in-service line, counting its own line.
- R6: The acknowledge edge picks the highest-priority eligible request and sets its in-service bit. On the next cycle, vector-valid is high for one cycle with vector = base OR line number. The low three bits of the base byte are ignored.
- R7: An even-address write of 0x60+n clears in-service bit n and leaves every other in-service bit unchanged.
- R8: An even-address write of 0x0A makes later even-address reads return the request register. A write of 0x0B makes them return the in-service register. The choice persists until changed, and a configuration start restores the request register.
- R9: An acknowledge with no eligible request returns vector base+7 and sets no in-service bit. This also applies when line 7 is masked.
- R10: With automatic retirement selected, an acknowledge returns its vector but leaves the in-service register at 0.
- R11: In a master, when the acknowledged line has its cascade-byte bit set, the master puts the line number on the select output and does not return a vector itself. That line's in-service bit stays set until a specific retirement command reaches the master.
- R12: A slave answers an acknowledge only when the select input is valid and carries the identity held in the low three bits of its cascade byte. Otherwise it produces no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 selects master role, 0 selects slave role |
| bus_addr | input | 1 | Register address: 0 even, 1 odd |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_lines | input | 8 | Level-sensitive request lines |
| int_out | output | 1 | Interrupt request toward the processor |
| ack | input | 1 | Acknowledge pulse from the processor |
| vec_valid | output | 1 | Vector returned this cycle |
| vec_out | output | 8 | Returned vector |
| casc_sel_valid_in | input | 1 | Slave: select bus valid |
| casc_sel_id_in | input | 3 | Slave: selected identity |
| casc_sel_valid_out | output | 1 | Master: acknowledged line belongs to a slave |
| casc_sel_id_out | output | 3 | Master: line number sent to the slaves |

## Verification
The priority logic is exercised with pairs of simultaneous requests, with a higher-priority line arriving while a lower one is in service, and with a lower line held back behind an in-service bit. These cases separate correct nesting from plain first-set arbitration. Retirement commands are applied while two in-service bits are set, which shows that only the named bit is cleared. A request that disappears before acknowledge is tested both with line 7 unmasked and with it masked. A master and a slave wired together show that the select bus, and not the acknowledge alone, decides which instance returns the vector.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int BYTE_W = 8;
   localparam int CASC_ID_W = 3;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [1:0] {
      CFG_IDLE,
      CFG_BASE,
      CFG_CASC,
      CFG_MODE
   } cfg_state_e;

   typedef struct packed {
      byte_t base;   // low index bits held at zero
      byte_t casc;   // master: slave map, slave: identity in [2:0]
      logic  aeoi;   // automatic retirement on acknowledge
   } cfg_t;

   localparam logic [4:0] CMD_EOI_HI = 5'b01100;
endpackage

// File: rtl/pic_regif.sv
module pic_regif
   import pic_pkg::*;
#(
   parameter int         LINES    = 8,
   parameter logic [7:0] RST_BASE = 8'h00
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             addr_odd,
   input  byte_t            wdata,
   output cfg_t             cfg,
   output logic [LINES-1:0] imr,
   output logic             rd_isr_sel,
   output logic             init_start,
   output logic             eoi_valid,
   output logic [2:0]       eoi_idx
);
   localparam int IDX_W = $clog2(LINES);
   localparam byte_t BASE_KEEP = byte_t'(~((1 << IDX_W) - 1));

   cfg_state_e state_q;
   logic       even_wr, odd_wr, sel_wr;

   assign even_wr    = wr_en && !addr_odd;
   assign odd_wr     = wr_en && addr_odd;
   assign init_start = even_wr && wdata[4];
   assign eoi_valid  = even_wr && (wdata[7:3] == CMD_EOI_HI) &&
                       (int'(wdata[2:0]) < LINES);
   assign eoi_idx    = wdata[2:0];
   assign sel_wr     = even_wr && (wdata[7:5] == 3'b000) &&
                       (wdata[4:3] == 2'b01) && wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= CFG_IDLE;
         cfg.base   <= RST_BASE & BASE_KEEP;
         cfg.casc   <= '0;
         cfg.aeoi   <= 1'b0;
         imr        <= '1;
         rd_isr_sel <= 1'b0;
      end else begin
         if (init_start) begin
            state_q    <= CFG_BASE;
            rd_isr_sel <= 1'b0;
         end else if (sel_wr) begin
            rd_isr_sel <= wdata[0];
         end

         if (odd_wr) begin
            unique case (state_q)
               CFG_BASE: begin
                  cfg.base <= wdata & BASE_KEEP;
                  state_q  <= CFG_CASC;
               end
               CFG_CASC: begin
                  cfg.casc <= wdata;
                  state_q  <= CFG_MODE;
               end
               CFG_MODE: begin
                  if (wdata[0]) begin
                     cfg.aeoi <= wdata[1];
                     state_q  <= CFG_IDLE;
                  end
               end
               default: imr <= wdata[LINES-1:0];
            endcase
         end
      end
   end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int LINES = 8
)(
   input  logic [LINES-1:0]         pend,
   input  logic [LINES-1:0]         isr,
   output logic [LINES-1:0]         elig,
   output logic                     int_req,
   output logic                     win_any,
   output logic [$clog2(LINES)-1:0] win_idx
);
   localparam int IDX_W = $clog2(LINES);

   // a line may interrupt only when nothing of equal or higher rank is in service
   for (genvar gi = 0; gi < LINES; gi++) begin : g_line
      assign elig[gi] = pend[gi] & ~(|isr[gi:0]);
   end

   assign int_req = |elig;
   assign win_any = |elig;

   always_comb begin
      win_idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (elig[i]) win_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/pic_service.sv
module pic_service
   import pic_pkg::*;
#(
   parameter int LINES       = 8,
   parameter int SYNC_STAGES = 1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LINES-1:0]         irq_lines,
   input  logic                     is_master,
   input  logic                     ack,
   input  logic                     casc_sel_valid_in,
   input  logic [CASC_ID_W-1:0]     casc_sel_id_in,
   input  cfg_t                     cfg,
   input  logic                     init_start,
   input  logic                     eoi_valid,
   input  logic [2:0]               eoi_idx,
   input  logic                     win_any,
   input  logic [$clog2(LINES)-1:0] win_idx,
   output logic [LINES-1:0]         irr_q,
   output logic [LINES-1:0]         isr_q,
   output logic                     vec_valid,
   output byte_t                    vec_out,
   output logic                     casc_sel_valid_out,
   output logic [CASC_ID_W-1:0]     casc_sel_id_out
);
   localparam int IDX_W = $clog2(LINES);
   localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(LINES - 1);

   logic [LINES-1:0] lines_s, isr_d;
   logic             slave_hit, take, to_slave, give_vec;
   logic [IDX_W-1:0] vec_idx;

   if (SYNC_STAGES == 2) begin : g_sync2
      logic [LINES-1:0] meta_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) meta_q <= '0;
         else        meta_q <= irq_lines;
      end
      assign lines_s = meta_q;
   end else begin : g_sync1
      assign lines_s = irq_lines;
   end

   assign slave_hit = !is_master && casc_sel_valid_in &&
                      (casc_sel_id_in == cfg.casc[CASC_ID_W-1:0]);
   assign take      = ack && (is_master || slave_hit);
   assign to_slave  = is_master && ack && win_any && cfg.casc[win_idx];
   assign give_vec  = take && !to_slave;
   assign vec_idx   = win_any ? win_idx : SPUR_IDX;

   assign casc_sel_valid_out = to_slave;
   assign casc_sel_id_out    = CASC_ID_W'(win_idx);

   always_comb begin
      isr_d = isr_q;
      if (take && win_any && !cfg.aeoi) isr_d[win_idx] = 1'b1;
      if (eoi_valid) isr_d[eoi_idx[IDX_W-1:0]] = 1'b0;
      if (init_start) isr_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q     <= '0;
         isr_q     <= '0;
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         irr_q     <= lines_s;
         isr_q     <= isr_d;
         vec_valid <= give_vec;
         if (give_vec) vec_out <= cfg.base | byte_t'(vec_idx);
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int         LINES       = 8,
   parameter int         SYNC_STAGES = 1,
   parameter logic [7:0] RST_BASE    = 8'h00
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        is_master,
   input  logic        bus_addr,
   input  logic        bus_wr,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata,
   input  logic [7:0]  irq_lines,
   output logic        int_out,
   input  logic        ack,
   output logic        vec_valid,
   output logic [7:0]  vec_out,
   input  logic        casc_sel_valid_in,
   input  logic [2:0]  casc_sel_id_in,
   output logic        casc_sel_valid_out,
   output logic [2:0]  casc_sel_id_out
);
   localparam int IDX_W = $clog2(LINES);

   if (!(LINES == 2 || LINES == 4 || LINES == 8)) begin : g_bad_lines
      $error("prio_irq_ctrl: LINES must be 2, 4 or 8");
   end
   if (!(SYNC_STAGES == 1 || SYNC_STAGES == 2)) begin : g_bad_sync
      $error("prio_irq_ctrl: SYNC_STAGES must be 1 or 2");
   end

   cfg_t             cfg;
   logic [LINES-1:0] imr_q, irr_q, isr_q, elig;
   logic             rd_isr_sel, init_start, eoi_valid, win_any, aeoi_on;
   logic [2:0]       eoi_idx;
   logic [IDX_W-1:0] win_idx;

   pic_regif #(.LINES(LINES), .RST_BASE(RST_BASE)) u_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr),
      .addr_odd   (bus_addr),
      .wdata      (bus_wdata),
      .cfg        (cfg),
      .imr        (imr_q),
      .rd_isr_sel (rd_isr_sel),
      .init_start (init_start),
      .eoi_valid  (eoi_valid),
      .eoi_idx    (eoi_idx)
   );

   pic_prio #(.LINES(LINES)) u_prio (
      .pend    (irr_q[LINES-1:0] & ~imr_q),
      .isr     (isr_q),
      .elig    (elig),
      .int_req (int_out),
      .win_any (win_any),
      .win_idx (win_idx)
   );

   pic_service #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_service (
      .clk                (clk),
      .rst_n              (rst_n),
      .irq_lines          (irq_lines[LINES-1:0]),
      .is_master          (is_master),
      .ack                (ack),
      .casc_sel_valid_in  (casc_sel_valid_in),
      .casc_sel_id_in     (casc_sel_id_in),
      .cfg                (cfg),
      .init_start         (init_start),
      .eoi_valid          (eoi_valid),
      .eoi_idx            (eoi_idx),
      .win_any            (win_any),
      .win_idx            (win_idx),
      .irr_q              (irr_q),
      .isr_q              (isr_q),
      .vec_valid          (vec_valid),
      .vec_out            (vec_out),
      .casc_sel_valid_out (casc_sel_valid_out),
      .casc_sel_id_out    (casc_sel_id_out)
   );

   assign aeoi_on   = cfg.aeoi;
   assign bus_rdata = bus_addr   ? 8'(imr_q) :
                      rd_isr_sel ? 8'(isr_q) : 8'(irr_q);
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
   parameter int LINES = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             is_master,
   input logic             ack,
   input logic             int_out,
   input logic             vec_valid,
   input logic             casc_sel_valid_out,
   input logic             aeoi_on,
   input logic             bus_wr,
   input logic             bus_addr,
   input logic [7:0]       bus_wdata,
   input logic [LINES-1:0] irr_q,
   input logic [LINES-1:0] imr_q,
   input logic [LINES-1:0] isr_q,
   input logic [LINES-1:0] elig
);
   // R4: interrupt output only with some unmasked request
   p_int_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr_q & ~imr_q) != '0));

   // R6: vector only in the cycle after an acknowledge
   p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(ack));

   // R6: at most one in-service bit set per cycle
   p_isr_one_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr_q & ~$past(isr_q)));

   // R6: in-service bits are only set by an acknowledge
   p_isr_set_by_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((isr_q & ~$past(isr_q)) != '0) |-> $past(ack));

   // R7: specific retirement clears the named bit
   p_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && bus_wdata[7:3] == 5'b01100 &&
       int'(bus_wdata[2:0]) < LINES)
      |=> !(|(isr_q & (LINES'(1) << $past(bus_wdata[2:0])))));

   // R9: a spurious acknowledge sets nothing in service
   p_spur_no_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && elig == '0) |=> ((isr_q & ~$past(isr_q)) == '0));

   // R10: automatic retirement leaves in-service untouched
   p_aeoi_no_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && aeoi_on) |=> ((isr_q & ~$past(isr_q)) == '0));

   // R11: select bus driven only by a master during acknowledge
   p_casc_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
      casc_sel_valid_out |-> (is_master && ack));
endmodule

bind prio_irq_ctrl pic_chk #(.LINES(LINES)) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .is_master          (is_master),
   .ack                (ack),
   .int_out            (int_out),
   .vec_valid          (vec_valid),
   .casc_sel_valid_out (casc_sel_valid_out),
   .aeoi_on            (aeoi_on),
   .bus_wr             (bus_wr),
   .bus_addr           (bus_addr),
   .bus_wdata          (bus_wdata),
   .irr_q              (irr_q),
   .imr_q              (imr_q),
   .isr_q              (isr_q),
   .elig               (elig)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ack = 1'b0;
   logic       m_addr = 1'b0, m_wr = 1'b0, s_addr = 1'b0, s_wr = 1'b0;
   logic [7:0] m_wdata = '0, s_wdata = '0, m_rdata, s_rdata;
   logic [7:0] m_lines = '0, s_lines = '0, m_irq;
   logic       m_int, s_int, m_vv, s_vv, m_csv, s_csv;
   logic [7:0] m_vec, s_vec;
   logic [2:0] m_csid, s_csid;
   int         n_checks = 0, n_fail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   assign m_irq = m_lines | {5'b0, s_int, 2'b0};

   prio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .is_master(1'b1),
      .bus_addr(m_addr), .bus_wr(m_wr), .bus_wdata(m_wdata), .bus_rdata(m_rdata),
      .irq_lines(m_irq), .int_out(m_int), .ack(ack),
      .vec_valid(m_vv), .vec_out(m_vec),
      .casc_sel_valid_in(1'b0), .casc_sel_id_in(3'd0),
      .casc_sel_valid_out(m_csv), .casc_sel_id_out(m_csid));

   prio_irq_ctrl dut_s (
      .clk(clk), .rst_n(rst_n), .is_master(1'b0),
      .bus_addr(s_addr), .bus_wr(s_wr), .bus_wdata(s_wdata), .bus_rdata(s_rdata),
      .irq_lines(s_lines), .int_out(s_int), .ack(ack),
      .vec_valid(s_vv), .vec_out(s_vec),
      .casc_sel_valid_in(m_csv), .casc_sel_id_in(m_csid),
      .casc_sel_valid_out(s_csv), .casc_sel_id_out(s_csid));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input bit sl, input bit a, input logic [7:0] d);
      @(negedge clk);
      if (sl) begin s_addr = a; s_wdata = d; s_wr = 1'b1; end
      else    begin m_addr = a; m_wdata = d; m_wr = 1'b1; end
      @(negedge clk);
      m_wr = 1'b0; s_wr = 1'b0;
   endtask

   task automatic rd(input bit sl, input bit a, output logic [7:0] d);
      if (sl) s_addr = a; else m_addr = a;
      #1;
      d = sl ? s_rdata : m_rdata;
   endtask

   task automatic do_ack(output logic mv, output logic [7:0] mvec,
                         output logic sv, output logic [7:0] svec);
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      mv = m_vv; mvec = m_vec; sv = s_vv; svec = s_vec;
   endtask

   task automatic cfg_seq(input bit sl, input logic [7:0] base,
                          input logic [7:0] casc, input logic [7:0] mode);
      wr(sl, 1'b0, 8'h11);
      wr(sl, 1'b1, base);
      wr(sl, 1'b1, casc);
      wr(sl, 1'b1, mode);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(0, 1'b1, d); chk("R1 mask after reset", d, 8'hFF);
      rd(0, 1'b0, d); chk("R1 even read is request reg", d, 8'h00);
      chk("R1 int low", 8'(m_int), 8'h0);
      chk("R1 vec_valid low", 8'(m_vv), 8'h0);
      wr(0, 1'b0, 8'h0B);
      rd(0, 1'b0, d); chk("R1 in-service zero", d, 8'h00);
      wr(0, 1'b0, 8'h0A);
   endtask

   task automatic t_config();
      logic [7:0] d;
      cfg_seq(0, 8'h20, 8'h00, 8'h01);
      rd(0, 1'b1, d); chk("R2 config bytes leave mask", d, 8'hFF);
      wr(0, 1'b1, 8'h00);
      rd(0, 1'b1, d); chk("R4 mask write/read", d, 8'h00);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      wr(0, 1'b1, 8'h08);
      m_lines = 8'h08; step(1);
      chk("R4 masked line no int", 8'(m_int), 8'h0);
      rd(0, 1'b0, d); chk("R8 request reg shows masked line", d, 8'h08);
      wr(0, 1'b1, 8'h00);
      chk("R4 unmasked line raises int", 8'(m_int), 8'h1);
      m_lines = 8'h00; step(1);
   endtask

   task automatic t_priority();
      logic mv, sv; logic [7:0] mvec, svec, d;
      m_lines = 8'h28; step(1);
      chk("R5 int with requests", 8'(m_int), 8'h1);
      do_ack(mv, mvec, sv, svec);
      chk("R6 vec_valid", 8'(mv), 8'h1);
      chk("R6 vector line 3 wins", mvec, 8'h23);
      chk("R12 slave silent without select", 8'(sv), 8'h0);
      wr(0, 1'b0, 8'h0B);
      rd(0, 1'b0, d); chk("R6 in-service bit 3", d, 8'h08);
      chk("R5 lower line held back", 8'(m_int), 8'h0);
      m_lines = 8'h2A; step(1);
      chk("R5 higher line outranks in-service", 8'(m_int), 8'h1);
      do_ack(mv, mvec, sv, svec);
      chk("R6 nested vector line 1", mvec, 8'h21);
      rd(0, 1'b0, d); chk("R6 two in-service bits", d, 8'h0A);
      m_lines = 8'h20;
      wr(0, 1'b0, 8'h63);
      rd(0, 1'b0, d); chk("R7 only bit 3 cleared", d, 8'h02);
      chk("R5 line 5 still blocked by 1", 8'(m_int), 8'h0);
      wr(0, 1'b0, 8'h61);
      rd(0, 1'b0, d); chk("R8 selection persists, isr clear", d, 8'h00);
      chk("R5 line 5 now eligible", 8'(m_int), 8'h1);
      do_ack(mv, mvec, sv, svec);
      chk("R6 vector line 5", mvec, 8'h25);
      wr(0, 1'b0, 8'h65);
      wr(0, 1'b0, 8'h0A);
      rd(0, 1'b0, d); chk("R8 request reg selected again", d, 8'h20);
      m_lines = 8'h00; step(1);
   endtask

   task automatic t_spurious();
      logic mv, sv; logic [7:0] mvec, svec, d;
      wr(0, 1'b0, 8'h0B);
      m_lines = 8'h10; step(1);
      chk("R9 int before withdrawal", 8'(m_int), 8'h1);
      m_lines = 8'h00;
      do_ack(mv, mvec, sv, svec);
      chk("R9 spurious valid", 8'(mv), 8'h1);
      chk("R9 spurious vector", mvec, 8'h27);
      rd(0, 1'b0, d); chk("R9 no in-service", d, 8'h00);
      wr(0, 1'b1, 8'h80);
      m_lines = 8'h10; step(1);
      m_lines = 8'h00;
      do_ack(mv, mvec, sv, svec);
      chk("R9 spurious vector with line 7 masked", mvec, 8'h27);
      rd(0, 1'b0, d); chk("R9 masked case no in-service", d, 8'h00);
      wr(0, 1'b1, 8'h00);
   endtask

   task automatic t_mode_and_aeoi();
      logic mv, sv; logic [7:0] mvec, svec, d;
      wr(0, 1'b0, 8'h11);
      wr(0, 1'b1, 8'h47);
      wr(0, 1'b1, 8'h00);
      wr(0, 1'b1, 8'h00);
      wr(0, 1'b1, 8'h03);
      rd(0, 1'b1, d); chk("R3 bad mode byte rejected", d, 8'h00);
      rd(0, 1'b0, d); chk("R8 config start restores request select", d, 8'h00);
      m_lines = 8'h10; step(1);
      do_ack(mv, mvec, sv, svec);
      chk("R6 base low bits ignored", mvec, 8'h44);
      wr(0, 1'b0, 8'h0B);
      rd(0, 1'b0, d); chk("R10 auto retirement isr clear", d, 8'h00);
      chk("R10 int stays with request held", 8'(m_int), 8'h1);
      m_lines = 8'h00; step(1);
   endtask

   task automatic t_cascade();
      logic mv, sv; logic [7:0] mvec, svec, d;
      cfg_seq(0, 8'h20, 8'h04, 8'h01);
      cfg_seq(1, 8'h28, 8'h02, 8'h01);
      wr(1, 1'b1, 8'h00);
      s_lines = 8'h08; m_lines = 8'h01; step(2);
      chk("R11 master int from slave path", 8'(m_int), 8'h1);
      do_ack(mv, mvec, sv, svec);
      chk("R12 slave silent when master line wins", 8'(sv), 8'h0);
      chk("R6 master own vector", mvec, 8'h20);
      m_lines = 8'h00;
      wr(0, 1'b0, 8'h60);
      step(1);
      do_ack(mv, mvec, sv, svec);
      chk("R11 master returns no vector", 8'(mv), 8'h0);
      chk("R12 selected slave valid", 8'(sv), 8'h1);
      chk("R12 slave vector", svec, 8'h2B);
      wr(0, 1'b0, 8'h0B);
      rd(0, 1'b0, d); chk("R11 master in-service bit 2", d, 8'h04);
      s_lines = 8'h00;
      wr(1, 1'b0, 8'h0B);
      wr(1, 1'b0, 8'h63);
      rd(1, 1'b0, d); chk("R7 slave retired", d, 8'h00);
      rd(0, 1'b0, d); chk("R11 master bit 2 held after slave retire", d, 8'h04);
      wr(0, 1'b0, 8'h62);
      rd(0, 1'b0, d); chk("R11 master bit 2 retired", d, 8'h00);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_config();
      t_mask();
      t_priority();
      t_spurious();
      t_mode_and_aeoi();
      t_cascade();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=%h expected=%h", 8'h0, 8'h1);
         summary();
         $finish;
      end
   end
endmodule